// File: doc/BRIEF.md
# DDR2 Rank Command Timing Gate

This block sits on the controller side of a DDR2 interface and watches the decoded command stream for one rank. From the commands it accepts and the current mode settings (CAS latency, additive latency, burst length, write recovery and the slow power-down exit choice), it keeps a set of small down-counters. From those it tells the scheduler, class by class, which commands may legally be issued this cycle. It also keeps a bitmap of which banks are open, so that it knows whether a precharge leaves the rank idle.

For a read or write with auto-precharge, the block counts the delay the device needs before that bank is closed. It then raises a one-clock completion pulse on that bank's line, and the bank is marked closed. A command issued while its class is not allowed is dropped: it changes no state, and it sets a sticky violation flag that only reset clears.

The scheduler samples the `allow_*` outputs during a cycle and presents at most one command per cycle on `cmd`. The command is taken at the rising edge that ends that cycle. All delays below are counted from that cycle, which is the command cycle, numbered 0.

Top module: `ddr2_cmd_gate`

## Requirements
- R1: After reset no bank is open, the rank is neither powered down nor in self refresh, and no counter is running. `allow_act`, `allow_pre`, `allow_aref`, `allow_sref` and `allow_pden` are high. `allow_rd`, `allow_wr`, `allow_pdex`, `allow_srex`, `rank_active`, `ap_done` and `violation` are low.
- R2: After an accepted read with auto-precharge (code 3), `ap_done[bank]` is high for exactly one cycle. That cycle is AL + BL/2 − 2 + T_RTP cycles after the command, where BL is 8 when `burst8` is 1 and 4 otherwise. The bank counts as closed from the next cycle.
- R3: After an accepted write with auto-precharge (code 5), `ap_done[bank]` is high for exactly one cycle, AL + CL − 1 + BL/2 + `wr_rec` cycles after the command. No other bank's line pulses.
- R4: After a power-down exit (code 12) from precharge power-down, `allow_act`, `allow_wr`, `allow_pre`, `allow_aref`, `allow_sref` and `allow_pden` are low until T_XP cycles after the exit command. They are high from that cycle on.
- R5: After a power-down exit from active power-down, `allow_rd` is low until the exit delay has passed and high from then on, while non-read classes are allowed at once. The exit delay is T_XARD cycles when `slow_exit` is 0, and 6 − AL cycles (at least 1) when `slow_exit` is 1.
- R6: After a self-refresh exit (code 10), the non-read classes are blocked until T_XSNR cycles after the exit, and `allow_rd` is blocked until T_XSRD cycles after it.
- R7: After an accepted auto refresh (code 8), `allow_act` and `allow_aref` are low until T_RFC cycles after the refresh command.
- R8: An activate (code 1) opens the bank on `bank`. A precharge (code 6) closes that one bank, and a precharge-all (code 7) closes every bank. `rank_active` is high while any bank is open, so closing the last open bank makes it low, and closing one of several leaves it high.
- R9: Power-down entry (code 11) with a bank open enters active power-down, and with no bank open it enters precharge power-down. Self-refresh entry (code 9) needs all banks closed. While powered down only `allow_pdex` is high, and while in self refresh only `allow_srex` is high. Reads (codes 2 and 3) and writes (codes 4 and 5) need an open bank.
- R10: A command from codes 1 to 12 presented while its class is not allowed has no effect on banks, mode or counters. It sets `violation`, which stays high until reset. Code 0 (no operation) and codes 13 to 15 have no effect and never set `violation`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 4 | Command code: 0 nop, 1 activate, 2 read, 3 read+AP, 4 write, 5 write+AP, 6 precharge, 7 precharge all, 8 auto refresh, 9 self-refresh entry, 10 self-refresh exit, 11 power-down entry, 12 power-down exit |
| bank | input | 2 | Bank address of the command |
| cas_lat | input | 3 | CAS latency in clocks |
| add_lat | input | 3 | Additive latency in clocks |
| burst8 | input | 1 | 1 = burst length 8, 0 = burst length 4 |
| wr_rec | input | 3 | Write recovery in clocks |
| slow_exit | input | 1 | 1 = slow exit from active power-down |
| allow_act | output | 1 | Activate may be issued |
| allow_rd | output | 1 | Read (with or without AP) may be issued |
| allow_wr | output | 1 | Write (with or without AP) may be issued |
| allow_pre | output | 1 | Precharge or precharge-all may be issued |
| allow_aref | output | 1 | Auto refresh may be issued |
| allow_sref | output | 1 | Self-refresh entry may be issued |
| allow_pden | output | 1 | Power-down entry may be issued |
| allow_pdex | output | 1 | Power-down exit may be issued |
| allow_srex | output | 1 | Self-refresh exit may be issued |
| ap_done | output | 4 | Per-bank one-cycle auto-precharge completion pulse |
| rank_active | output | 1 | At least one bank is open |
| violation | output | 1 | Sticky: a blocked command was presented |

## Verification
Every blocking window is probed on both sides of its edge: the last blocked cycle and the first allowed one. A counter loaded with N instead of N − 1 would show up as a window one cycle too long or too short. The auto-precharge delays are checked with both burst lengths and with non-zero additive latency, so a missing AL term or a wrong BL/2 term moves the pulse. The bench also checks that the pulse lands on the right bank and lasts one cycle. The tests split fast from slow active power-down exit and precharge from active power-down exit. A design that applied tXP to reads, or tXARD to activates, would block the wrong class. The self-refresh test relies on tXSRD being far longer than tXSNR, so a shared counter cannot pass. Blocked commands are issued on purpose during power-down and on an idle rank, and the open-bank state seen afterwards shows whether a dropped command leaked into it.

// File: rtl/ddr2_gate_pkg.sv
package ddr2_gate_pkg;

  typedef enum logic [3:0] {
    C_NOP  = 4'd0,
    C_ACT  = 4'd1,
    C_RD   = 4'd2,
    C_RDAP = 4'd3,
    C_WR   = 4'd4,
    C_WRAP = 4'd5,
    C_PRE  = 4'd6,
    C_PREA = 4'd7,
    C_REF  = 4'd8,
    C_SRE  = 4'd9,
    C_SRX  = 4'd10,
    C_PDE  = 4'd11,
    C_PDX  = 4'd12
  } cmd_e;

  typedef enum logic [1:0] {
    RK_NORM   = 2'd0,
    RK_PD_PRE = 2'd1,
    RK_PD_ACT = 2'd2,
    RK_SELF   = 2'd3
  } rank_e;

  // Read with auto-precharge: clocks from command to bank closed.
  function automatic int rd_ap_delay(logic [2:0] al, logic bl8, int rtp);
    return int'(al) + (bl8 ? 4 : 2) - 2 + rtp;
  endfunction

  // Write with auto-precharge: clocks from command to bank closed.
  function automatic int wr_ap_delay(logic [2:0] al, logic [2:0] cl, logic bl8,
                                     logic [2:0] wr);
    return int'(al) + int'(cl) - 1 + (bl8 ? 4 : 2) + int'(wr);
  endfunction

  // Read blocking window after a slow exit from active power-down.
  function automatic int slow_exit_delay(logic [2:0] al);
    return (al >= 3'd6) ? 1 : 6 - int'(al);
  endfunction

  // Counter preload for a window of n clocks (allowed again at distance n).
  function automatic int load_of(int n);
    return (n <= 1) ? 0 : n - 1;
  endfunction

endpackage

// File: rtl/ddr2_gap_timer.sv
module ddr2_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_GAP_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    load && (load_val != '0) |=> busy); // R4
  AST_GAP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !busy |=> !busy); // R6
endmodule

// File: rtl/ddr2_ap_timer.sv
module ddr2_ap_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] delay,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= delay;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == W'(1));

  AST_AP_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !load |=> !done); // R2
  AST_AP_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !done && (cnt == '0) |=> !done); // R3
endmodule

// File: rtl/ddr2_rank_track.sv
module ddr2_rank_track
  import ddr2_gate_pkg::*;
#(
  parameter int NB = 4,
  localparam int BA_W = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_act,
  input  logic            acc_pre,
  input  logic            acc_prea,
  input  logic            acc_pde,
  input  logic            acc_pdx,
  input  logic            acc_sre,
  input  logic            acc_srx,
  input  logic [BA_W-1:0] bank,
  input  logic [NB-1:0]   ap_close,
  output rank_e           mode,
  output logic [NB-1:0]   open_banks
);
  logic [NB-1:0] open_nxt;
  rank_e         mode_nxt;

  always_comb begin
    open_nxt = open_banks & ~ap_close;
    if (acc_act)  open_nxt[bank] = 1'b1;
    if (acc_pre)  open_nxt[bank] = 1'b0;
    if (acc_prea) open_nxt = '0;
  end

  always_comb begin
    mode_nxt = mode;
    unique case (mode)
      RK_NORM: begin
        if (acc_pde)      mode_nxt = (open_banks != '0) ? RK_PD_ACT : RK_PD_PRE;
        else if (acc_sre) mode_nxt = RK_SELF;
      end
      RK_PD_PRE, RK_PD_ACT: if (acc_pdx) mode_nxt = RK_NORM;
      RK_SELF:              if (acc_srx) mode_nxt = RK_NORM;
      default:              mode_nxt = RK_NORM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_banks <= '0;
      mode       <= RK_NORM;
    end else begin
      open_banks <= open_nxt;
      mode       <= mode_nxt;
    end
  end

  AST_LAST_BANK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pre && (open_banks == (NB'(1) << bank)) && (ap_close == '0) |=> (open_banks == '0)); // R8
  AST_OTHERS_KEEP_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pre && ((open_banks & ~(NB'(1) << bank)) != '0) && (ap_close == '0) |=> (open_banks != '0)); // R8
  AST_AP_CLOSES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_close != '0) && !acc_act |=> ((open_banks & $past(ap_close)) == '0)); // R2
endmodule

// File: rtl/ddr2_cmd_gate.sv
module ddr2_cmd_gate
  import ddr2_gate_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_XP      = 3,
  parameter int T_XARD    = 2,
  parameter int T_XSNR    = 30,
  parameter int T_XSRD    = 200,
  parameter int T_RFC     = 26,
  parameter int T_RTP     = 2,
  parameter int AP_W      = 6,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int GAP_W    = $clog2(T_XP + T_XARD + T_XSNR + T_XSRD + T_RFC + 8)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           cmd,
  input  logic [BA_W-1:0]      bank,
  input  logic [2:0]           cas_lat,
  input  logic [2:0]           add_lat,
  input  logic                 burst8,
  input  logic [2:0]           wr_rec,
  input  logic                 slow_exit,
  output logic                 allow_act,
  output logic                 allow_rd,
  output logic                 allow_wr,
  output logic                 allow_pre,
  output logic                 allow_aref,
  output logic                 allow_sref,
  output logic                 allow_pden,
  output logic                 allow_pdex,
  output logic                 allow_srex,
  output logic [NUM_BANKS-1:0] ap_done,
  output logic                 rank_active,
  output logic                 violation
);
  localparam int NT      = 5;
  localparam int TI_XP   = 0;
  localparam int TI_XARD = 1;
  localparam int TI_XSNR = 2;
  localparam int TI_XSRD = 3;
  localparam int TI_RFC  = 4;

  rank_e                mode;
  logic [NUM_BANKS-1:0] open_banks;
  logic [NT-1:0]        tm_load;
  logic [GAP_W-1:0]     tm_val [NT];
  logic [NT-1:0]        tm_busy;

  // Named internal events for the assertions.
  logic in_norm, nonrd_ok, rd_ok, rfc_ok;
  logic cmd_known, cmd_ok, cmd_blocked;
  logic acc_act, acc_rdap, acc_wrap, acc_pre, acc_prea, acc_ref;
  logic acc_sre, acc_srx, acc_pde, acc_pdx;
  logic [AP_W-1:0] rd_delay, wr_delay;

  assign in_norm     = (mode == RK_NORM);
  assign rank_active = (open_banks != '0);
  assign nonrd_ok    = !tm_busy[TI_XP] && !tm_busy[TI_XSNR];
  assign rd_ok       = !tm_busy[TI_XARD] && !tm_busy[TI_XSRD];
  assign rfc_ok      = !tm_busy[TI_RFC];

  assign allow_act  = in_norm && nonrd_ok && rfc_ok;
  assign allow_rd   = in_norm && rd_ok && rank_active;
  assign allow_wr   = in_norm && nonrd_ok && rank_active;
  assign allow_pre  = in_norm && nonrd_ok;
  assign allow_aref = in_norm && nonrd_ok && rfc_ok && !rank_active;
  assign allow_sref = in_norm && nonrd_ok && !rank_active;
  assign allow_pden = in_norm && nonrd_ok;
  assign allow_pdex = (mode == RK_PD_PRE) || (mode == RK_PD_ACT);
  assign allow_srex = (mode == RK_SELF);

  always_comb begin
    cmd_known = 1'b1;
    cmd_ok    = 1'b0;
    case (cmd)
      C_ACT:          cmd_ok = allow_act;
      C_RD, C_RDAP:   cmd_ok = allow_rd;
      C_WR, C_WRAP:   cmd_ok = allow_wr;
      C_PRE, C_PREA:  cmd_ok = allow_pre;
      C_REF:          cmd_ok = allow_aref;
      C_SRE:          cmd_ok = allow_sref;
      C_SRX:          cmd_ok = allow_srex;
      C_PDE:          cmd_ok = allow_pden;
      C_PDX:          cmd_ok = allow_pdex;
      default:        cmd_known = 1'b0;
    endcase
  end

  assign cmd_blocked = cmd_known && !cmd_ok;
  assign acc_act  = (cmd == C_ACT)  && cmd_ok;
  assign acc_rdap = (cmd == C_RDAP) && cmd_ok;
  assign acc_wrap = (cmd == C_WRAP) && cmd_ok;
  assign acc_pre  = (cmd == C_PRE)  && cmd_ok;
  assign acc_prea = (cmd == C_PREA) && cmd_ok;
  assign acc_ref  = (cmd == C_REF)  && cmd_ok;
  assign acc_sre  = (cmd == C_SRE)  && cmd_ok;
  assign acc_srx  = (cmd == C_SRX)  && cmd_ok;
  assign acc_pde  = (cmd == C_PDE)  && cmd_ok;
  assign acc_pdx  = (cmd == C_PDX)  && cmd_ok;

  // Exit and recovery windows.
  always_comb begin
    tm_load[TI_XP]   = acc_pdx && (mode == RK_PD_PRE);
    tm_load[TI_XARD] = acc_pdx && (mode == RK_PD_ACT);
    tm_load[TI_XSNR] = acc_srx;
    tm_load[TI_XSRD] = acc_srx;
    tm_load[TI_RFC]  = acc_ref;
    tm_val[TI_XP]    = GAP_W'(load_of(T_XP));
    tm_val[TI_XARD]  = slow_exit ? GAP_W'(load_of(slow_exit_delay(add_lat)))
                                 : GAP_W'(load_of(T_XARD));
    tm_val[TI_XSNR]  = GAP_W'(load_of(T_XSNR));
    tm_val[TI_XSRD]  = GAP_W'(load_of(T_XSRD));
    tm_val[TI_RFC]   = GAP_W'(load_of(T_RFC));
  end

  for (genvar t = 0; t < NT; t++) begin : g_gap
    ddr2_gap_timer #(.W(GAP_W)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tm_load[t]),
      .load_val (tm_val[t]),
      .busy     (tm_busy[t])
    );
  end

  // Auto-precharge completion, one counter per bank.
  assign rd_delay = AP_W'(rd_ap_delay(add_lat, burst8, T_RTP));
  assign wr_delay = AP_W'(wr_ap_delay(add_lat, cas_lat, burst8, wr_rec));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ap
    ddr2_ap_timer #(.W(AP_W)) u_ap (
      .clk   (clk),
      .rst_n (rst_n),
      .load  ((acc_rdap || acc_wrap) && (bank == BA_W'(b))),
      .delay (acc_wrap ? wr_delay : rd_delay),
      .done  (ap_done[b])
    );
  end

  ddr2_rank_track #(.NB(NUM_BANKS)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_act    (acc_act),
    .acc_pre    (acc_pre),
    .acc_prea   (acc_prea),
    .acc_pde    (acc_pde),
    .acc_pdx    (acc_pdx),
    .acc_sre    (acc_sre),
    .acc_srx    (acc_srx),
    .bank       (bank),
    .ap_close   (ap_done),
    .mode       (mode),
    .open_banks (open_banks)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) violation <= 1'b0;
    else        violation <= violation || cmd_blocked;
  end

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation); // R10
  AST_BLOCKED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_blocked && (ap_done == '0) |=> $stable(open_banks) && $stable(mode)); // R10
  AST_PD_ONLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pde |=> allow_pdex && !allow_act && !allow_rd && !allow_wr && !allow_pre && !allow_aref); // R9
  AST_SR_ONLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sre |=> allow_srex && !allow_pdex && !allow_pden && !allow_aref); // R9
  AST_RFC_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RFC > 1) && acc_ref |=> !allow_act && !allow_aref); // R7
  AST_SRX_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (T_XSNR > 1) && (T_XSRD > 1) && acc_srx |=> !allow_act && !allow_pden && !rd_ok); // R6
endmodule

// File: tb/ddr2_cmd_gate_tb.sv
`timescale 1ns/1ps
module ddr2_cmd_gate_tb_top;
  localparam int TXP = 3, TXARD = 2, TXSNR = 30, TXSRD = 200, TRFC = 26, TRTP = 2;
  localparam logic [3:0] NOP = 4'd0, ACT = 4'd1, RD = 4'd2, RDAP = 4'd3, WRAP = 4'd5,
                         PRE = 4'd6, PREA = 4'd7, REF = 4'd8, SRE = 4'd9, SRX = 4'd10,
                         PDE = 4'd11, PDX = 4'd12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cmd = NOP;
  logic [1:0] bank = '0;
  logic [2:0] cas_lat = 3'd4, add_lat = 3'd0, wr_rec = 3'd3;
  logic burst8 = 1'b0, slow_exit = 1'b0;
  logic allow_act, allow_rd, allow_wr, allow_pre, allow_aref, allow_sref;
  logic allow_pden, allow_pdex, allow_srex, rank_active, violation;
  logic [3:0] ap_done;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ddr2_cmd_gate dut_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .cas_lat(cas_lat),
    .add_lat(add_lat), .burst8(burst8), .wr_rec(wr_rec), .slow_exit(slow_exit),
    .allow_act(allow_act), .allow_rd(allow_rd), .allow_wr(allow_wr),
    .allow_pre(allow_pre), .allow_aref(allow_aref), .allow_sref(allow_sref),
    .allow_pden(allow_pden), .allow_pdex(allow_pdex), .allow_srex(allow_srex),
    .ap_done(ap_done), .rank_active(rank_active), .violation(violation));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive at the current falling edge; return one cycle later (distance 1).
  task automatic issue(logic [3:0] c, logic [1:0] b);
    cmd = c; bank = b;
    @(negedge clk);
    cmd = NOP;
  endtask

  task automatic do_reset();
    cmd = NOP; rst_n = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 allow group high", {allow_act, allow_pre, allow_aref, allow_sref, allow_pden}, 5'h1f);
    chk("R1 allow group low", {allow_rd, allow_wr, allow_pdex, allow_srex}, 0);
    chk("R1 outputs low", {ap_done, rank_active, violation}, 0);
  endtask

  task automatic t_rdap(logic [2:0] al, logic b8, logic [1:0] b);
    int d = int'(al) + (b8 ? 4 : 2) - 2 + TRTP;
    do_reset();
    add_lat = al; burst8 = b8;
    issue(ACT, b);
    issue(RDAP, b);
    if (d > 2) wait_cyc(d - 2);
    chk("R2 before pulse", int'(ap_done), 0);
    wait_cyc(1);
    chk("R2 pulse on bank", int'(ap_done), 1 << b);
    wait_cyc(1);
    chk("R2 one wide", int'(ap_done), 0);
    chk("R2 bank closed", rank_active, 0);
  endtask

  task automatic t_wrap();
    int d;
    do_reset();
    add_lat = 3'd1; cas_lat = 3'd4; burst8 = 1'b1; wr_rec = 3'd3;
    d = 1 + 4 - 1 + 4 + 3;
    issue(ACT, 2'd2);
    issue(WRAP, 2'd2);
    wait_cyc(d - 2);
    chk("R3 before pulse", int'(ap_done), 0);
    wait_cyc(1);
    chk("R3 pulse bank2 only", int'(ap_done), 4);
    wait_cyc(1);
    chk("R3 one wide", int'(ap_done), 0);
  endtask

  task automatic t_banks();
    do_reset();
    issue(ACT, 2'd0);
    issue(ACT, 2'd1);
    issue(PRE, 2'd0);
    chk("R8 other bank open", rank_active, 1);
    issue(PRE, 2'd1);
    chk("R8 last bank closed", rank_active, 0);
    issue(ACT, 2'd3);
    issue(ACT, 2'd1);
    issue(PREA, 2'd0);
    chk("R8 precharge all", rank_active, 0);
  endtask

  task automatic t_pd_pre();
    do_reset();
    issue(PDE, 2'd0);
    chk("R9 pd only exit", {allow_pdex, allow_act, allow_rd, allow_wr, allow_pre, allow_aref}, 6'b100000);
    issue(ACT, 2'd1);
    chk("R10 blocked act flagged", violation, 1);
    issue(PDX, 2'd0);
    chk("R10 blocked act no effect", rank_active, 0);
    chk("R4 blocked at 1", {allow_act, allow_pre, allow_pden}, 0);
    wait_cyc(TXP - 2);
    chk("R4 blocked at TXP-1", {allow_act, allow_aref, allow_sref}, 0);
    wait_cyc(1);
    chk("R4 allowed at TXP", {allow_act, allow_pre, allow_aref, allow_sref, allow_pden}, 5'h1f);
  endtask

  task automatic t_pd_act(logic slow, logic [2:0] al);
    int w = slow ? ((al >= 6) ? 1 : 6 - int'(al)) : TXARD;
    do_reset();
    slow_exit = slow; add_lat = al;
    issue(ACT, 2'd1);
    issue(PDE, 2'd0);
    chk("R9 active pd keeps bank", {rank_active, allow_pdex}, 3);
    issue(PDX, 2'd0);
    chk("R5 non-read free", {allow_act, allow_wr}, 3);
    if (w > 2) wait_cyc(w - 2);
    chk("R5 read blocked at w-1", allow_rd, 0);
    wait_cyc(1);
    chk("R5 read allowed at w", allow_rd, 1);
  endtask

  task automatic t_sref();
    do_reset();
    issue(SRE, 2'd0);
    chk("R9 self refresh only exit", {allow_srex, allow_pdex, allow_pden, allow_act}, 4'b1000);
    issue(SRX, 2'd0);
    wait_cyc(TXSNR - 2);
    chk("R6 non-read blocked", {allow_act, allow_pre}, 0);
    wait_cyc(1);
    chk("R6 non-read released", {allow_act, allow_pre}, 3);
    issue(ACT, 2'd0);
    wait_cyc(TXSRD - 1 - (TXSNR + 1));
    chk("R6 read blocked at TXSRD-1", allow_rd, 0);
    wait_cyc(1);
    chk("R6 read released", allow_rd, 1);
  endtask

  task automatic t_refresh();
    do_reset();
    issue(REF, 2'd0);
    wait_cyc(TRFC - 2);
    chk("R7 blocked", {allow_act, allow_aref}, 0);
    wait_cyc(1);
    chk("R7 released", {allow_act, allow_aref}, 3);
  endtask

  task automatic t_violation();
    do_reset();
    issue(NOP, 2'd0);
    issue(4'd13, 2'd0);
    issue(4'd15, 2'd3);
    chk("R10 unknown codes ignored", {violation, rank_active, allow_act}, 1);
    issue(RD, 2'd0);
    chk("R10 read on idle rank flagged", violation, 1);
    wait_cyc(5);
    chk("R10 sticky", {violation, rank_active}, 2);
    do_reset();
    chk("R10 cleared by reset", violation, 0);
  endtask

  initial begin
    t_reset();
    t_rdap(3'd0, 1'b0, 2'd0);
    t_rdap(3'd2, 1'b1, 2'd3);
    t_wrap();
    t_banks();
    t_pd_pre();
    t_pd_act(1'b0, 3'd0);
    t_pd_act(1'b1, 3'd2);
    t_sref();
    t_refresh();
    t_violation();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule